// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block gathers the data bytes of a single write transaction into a small page buffer and later commits them to a 128 x 8 non-volatile array model in one self-timed programming cycle. A bus slave in front of it loads the starting word address, presents each received data byte with a one-cycle strobe, and signals when the bus STOP condition arrives. The block places each byte into a page slot chosen by the low address bits. It then programs every received slot at once and holds a busy flag for the full programming time.

The array is page-organised, with one row per page and one byte lane per slot. Its write port carries a lane-enable vector, a page index and a page-wide data word. A combinational read port lets the surrounding logic read back any location. The programming time is a counter of system clocks. Its default corresponds to 10 ms at 100 MHz, and a test can set a short value.

Top module: `page_commit_engine`

## Requirements
- R1: After reset `busy_o` is 0, `mem_we_o` is all zero and every array location reads 0xFF.
- R2: When `addr_load_i` is high and the block is idle, address bits [6:2] select the page and bits [1:0] select the first slot. Bytes buffered before the load are discarded.
- R3: Each accepted byte is stored in the current slot, and the slot then increments modulo 4. The page index does not change during the transaction.
- R4: When more than four bytes arrive before STOP, the slot wraps and each later byte overwrites the earlier one in its slot, so the last value per slot is programmed.
- R5: A `stop_i` with at least one buffered byte (a byte strobed in the same cycle counts) starts a cycle. `busy_o` rises on the next clock and stays high for exactly PROG_CLKS cycles.
- R6: In the last busy cycle the buffered slots are written together. Lane i of `mem_we_o` addresses word page*4+i, and its byte is `mem_wdata_o[8i+7:8i]`. The new contents read back once `busy_o` is low.
- R7: Slots that received no byte are not written and keep their previous contents.
- R8: A `stop_i` with an empty buffer, for example right after an address load, starts no cycle.
- R9: While `busy_o` is high, `addr_load_i`, `byte_vld_i` and `stop_i` have no effect.
- R10: The buffer is emptied by the commit. A later STOP without new bytes starts nothing, and a later transaction rewrites only its own slots.
- R11: When `addr_load_i` coincides with `byte_vld_i` or `stop_i`, the load takes effect and the byte or STOP is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Load starting word address |
| addr_i | input | 7 | Starting word address |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | STOP seen on the bus |
| busy_o | output | 1 | Programming cycle in progress |
| mem_we_o | output | 4 | Per-lane array write enables |
| mem_page_o | output | 5 | Array page index being written |
| mem_wdata_o | output | 32 | Page-wide write data, lane i at bits 8i+7:8i |
| rd_addr_i | input | 7 | Array read address |
| rd_data_o | output | 8 | Array read data |

## Verification
All inputs are registered at a rising edge. Address, slot and buffer changes take effect one edge after the strobe. `busy_o` is high from the first edge after an accepted STOP until the edge that ends PROG_CLKS cycles. The lane enables are asserted only in that final busy cycle, and the array shows the new bytes through the combinational read port right after that closing edge. The bench drives stimulus at falling edges and steps a behavioural model at each rising edge. It compares busy, lanes, page, data and read data at the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pcw_page_buf.sv
module pcw_page_buf
    import pcw_pkg::*;
#(
    parameter int PAGE_BYTES = 4,
    localparam int SLOT_W = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         wr_en_i,
    input  logic [SLOT_W-1:0]            wr_slot_i,
    input  byte_t                        wr_data_i,
    output logic [PAGE_BYTES*BYTE_W-1:0] data_o,
    output logic [PAGE_BYTES-1:0]        mask_o
);
    typedef struct packed {
        logic [PAGE_BYTES*BYTE_W-1:0] data;
        logic [PAGE_BYTES-1:0]        mask;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.mask = '0;
        end else if (wr_en_i) begin
            st_d.data[wr_slot_i*BYTE_W +: BYTE_W] = wr_data_i;
            st_d.mask[wr_slot_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/pcw_prog_timer.sv
module pcw_prog_timer #(
    parameter int PROG_CLKS = 1000000,
    localparam int CNT_W = (PROG_CLKS > 1) ? $clog2(PROG_CLKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(PROG_CLKS - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.busy && (st_q.cnt == '0);
endmodule

// File: rtl/pcw_array.sv
module pcw_array
    import pcw_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int PAGE_BYTES = 4,
    localparam int SLOT_W    = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - SLOT_W,
    localparam int NUM_PAGES = 1 << PAGE_W,
    localparam int ROW_W     = PAGE_BYTES * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PAGE_BYTES-1:0] we_i,
    input  logic [PAGE_W-1:0]     page_i,
    input  logic [ROW_W-1:0]      wdata_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output byte_t                 rd_data_o
);
    logic [ROW_W-1:0] rows_d [NUM_PAGES];
    logic [ROW_W-1:0] rows_q [NUM_PAGES];

    always_comb begin
        rows_d = rows_q;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (we_i[i]) rows_d[page_i][i*BYTE_W +: BYTE_W] = wdata_i[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) rows_q[p] <= '1;
        end else begin
            rows_q <= rows_d;
        end
    end

    logic [ROW_W-1:0] rd_row;
    assign rd_row    = rows_q[rd_addr_i[ADDR_W-1:SLOT_W]];
    assign rd_data_o = rd_row[rd_addr_i[SLOT_W-1:0]*BYTE_W +: BYTE_W];
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
    import pcw_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int PAGE_BYTES = 4,
    parameter int PROG_CLKS  = 1000000,
    localparam int SLOT_W    = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - SLOT_W,
    localparam int ROW_W     = PAGE_BYTES * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_load_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  byte_vld_i,
    input  logic [BYTE_W-1:0]     byte_i,
    input  logic                  stop_i,
    output logic                  busy_o,
    output logic [PAGE_BYTES-1:0] mem_we_o,
    output logic [PAGE_W-1:0]     mem_page_o,
    output logic [ROW_W-1:0]      mem_wdata_o,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [BYTE_W-1:0]     rd_data_o
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SLOT_W-1:0] slot;
    } seq_t;

    seq_t st_d, st_q;

    logic                  busy, done;
    logic                  accept, load, take, start, buf_clr;
    logic [PAGE_BYTES-1:0] mask;
    logic [ROW_W-1:0]      page_data;

    always_comb begin
        accept  = !busy;
        load    = accept && addr_load_i;
        take    = accept && byte_vld_i && !addr_load_i;
        start   = accept && stop_i && !addr_load_i && ((|mask) || take);
        buf_clr = load || done;
        st_d    = st_q;
        if (load) begin
            st_d.page = addr_i[ADDR_W-1:SLOT_W];
            st_d.slot = addr_i[SLOT_W-1:0];
        end else if (take) begin
            st_d.slot = st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pcw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_en_i   (take),
        .wr_slot_i (st_q.slot),
        .wr_data_i (byte_i),
        .data_o    (page_data),
        .mask_o    (mask)
    );

    pcw_prog_timer #(.PROG_CLKS(PROG_CLKS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    assign busy_o      = busy;
    assign mem_we_o    = done ? mask : '0;
    assign mem_page_o  = st_q.page;
    assign mem_wdata_o = page_data;

    pcw_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (mem_we_o),
        .page_i    (st_q.page),
        .wdata_i   (page_data),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/pcw_checks.sv
module pcw_checks #(
    parameter int PAGE_BYTES = 4,
    parameter int PAGE_W     = 5,
    parameter int PROG_CLKS  = 1000000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  addr_load_i,
    input logic                  stop_i,
    input logic                  busy_o,
    input logic [PAGE_BYTES-1:0] mem_we_o,
    input logic [PAGE_W-1:0]     mem_page_o
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == PROG_CLKS));

    p_start_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    p_we_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we_o) |-> busy_o);

    p_we_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we_o) |=> !busy_o);

    p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_page_o));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load_i && stop_i && !busy_o) |=> !busy_o);
endmodule

bind page_commit_engine pcw_checks #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_W     (PAGE_W),
    .PROG_CLKS  (PROG_CLKS)
) u_pcw_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_load_i (addr_load_i),
    .stop_i      (stop_i),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_page_o  (mem_page_o)
);

// File: tb/page_commit_engine_test.sv
module page_commit_engine_test;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b0;
    logic [6:0]  a = '0;
    logic        bv = 1'b0;
    logic [7:0]  d = '0;
    logic        sp = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic        busy;
    logic [3:0]  we;
    logic [4:0]  page;
    logic [31:0] wdata;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    int mem_m [128];
    int buf_m [4];
    bit have_m [4];
    int page_m = 0, slot_m = 0, bcnt = 0;

    always #5 clk = ~clk;

    page_commit_engine #(.PROG_CLKS(P)) uut (
        .clk(clk), .rst_n(rst_n), .addr_load_i(ld), .addr_i(a),
        .byte_vld_i(bv), .byte_i(d), .stop_i(sp), .busy_o(busy),
        .mem_we_o(we), .mem_page_o(page), .mem_wdata_o(wdata),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    // behavioural reference, stepped on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem_m[i] = 255;
            for (int i = 0; i < 4; i++) begin buf_m[i] = 0; have_m[i] = 0; end
            page_m = 0; slot_m = 0; bcnt = 0;
        end else if (bcnt > 0) begin
            if (bcnt == 1) begin
                for (int i = 0; i < 4; i++) begin
                    if (have_m[i]) mem_m[page_m*4 + i] = buf_m[i];
                    have_m[i] = 0;
                end
            end
            bcnt--;
        end else begin
            bit any;
            if (ld) begin
                page_m = a / 4; slot_m = a % 4;
                for (int i = 0; i < 4; i++) have_m[i] = 0;
            end else if (bv) begin
                buf_m[slot_m] = d; have_m[slot_m] = 1; slot_m = (slot_m + 1) % 4;
            end
            any = have_m[0] | have_m[1] | have_m[2] | have_m[3];
            if (sp && !ld && any) bcnt = P;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        int exp_we;
        exp_we = 0;
        if (bcnt == 1) for (int i = 0; i < 4; i++) if (have_m[i]) exp_we |= (1 << i);
        chk(busy == (bcnt > 0), "R5 busy", busy, bcnt > 0);
        chk(int'(we) == exp_we, "R6 lanes", we, exp_we);
        if (exp_we != 0) begin
            chk(int'(page) == page_m, "R3 page", page, page_m);
            for (int i = 0; i < 4; i++)
                if (have_m[i]) chk(int'(wdata[i*8 +: 8]) == buf_m[i], "R6 data", wdata[i*8 +: 8], buf_m[i]);
        end
        chk(int'(rd_data) == mem_m[rd_addr], "R7 readback", rd_data, mem_m[rd_addr]);
    endtask

    task automatic step(input bit l, input int ad, input bit b, input int dv, input bit s);
        @(negedge clk);
        compare();
        ld = l; a = 7'(ad); bv = b; d = 8'(dv); sp = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic expect_mem(input int ad, input int val, input string tag);
        rd_addr = 7'(ad);
        #1;
        chk(int'(rd_data) == val, tag, rd_data, val);
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(we == 4'b0, "R1 lanes", we, 0);
        for (int i = 0; i < 128; i++) expect_mem(i, 255, "R1 erased");
        rst_n = 1'b1;
        idle(2);

        // single byte mid-page: R2, R6, R7
        step(1, 'h15, 0, 0, 0); step(0, 0, 1, 'hA1, 0); step(0, 0, 0, 0, 1);
        idle(P + 2);
        expect_mem('h15, 'hA1, "R2 target");
        expect_mem('h14, 255, "R7 untouched");
        expect_mem('h16, 255, "R7 untouched");
        expect_mem('h17, 255, "R7 untouched");

        // full page from slot 2: R3
        step(1, 'h2A, 0, 0, 0);
        step(0, 0, 1, 'h11, 0); step(0, 0, 1, 'h22, 0);
        step(0, 0, 1, 'h33, 0); step(0, 0, 1, 'h44, 0);
        step(0, 0, 0, 0, 1);
        idle(P + 2);
        expect_mem('h2A, 'h11, "R3 slot2");
        expect_mem('h2B, 'h22, "R3 slot3");
        expect_mem('h28, 'h33, "R3 wrap slot0");
        expect_mem('h29, 'h44, "R3 slot1");
        expect_mem('h2C, 255, "R3 next page");

        // six bytes: R4 overwrite
        step(1, 'h40, 0, 0, 0);
        for (int i = 1; i <= 6; i++) step(0, 0, 1, i, 0);
        step(0, 0, 0, 0, 1);
        idle(P + 2);
        expect_mem('h40, 5, "R4 overwrite");
        expect_mem('h41, 6, "R4 overwrite");
        expect_mem('h42, 3, "R4 kept");
        expect_mem('h43, 4, "R4 kept");

        // empty stop: R8
        step(1, 'h50, 0, 0, 0); step(0, 0, 0, 0, 1); idle(2);
        chk(busy == 1'b0, "R8 no cycle", busy, 0);
        expect_mem('h50, 255, "R8 unchanged");

        // inputs during busy: R9
        step(1, 'h60, 0, 0, 0); step(0, 0, 1, 'h77, 0); step(0, 0, 0, 0, 1);
        step(1, 'h70, 0, 0, 0); step(0, 0, 1, 'h99, 0); step(0, 0, 0, 0, 1);
        idle(P + 2);
        expect_mem('h60, 'h77, "R9 committed");
        expect_mem('h61, 'h99 == 0 ? 0 : 255, "R9 byte ignored");
        expect_mem('h70, 255, "R9 load ignored");

        // buffer emptied by commit: R10
        step(0, 0, 0, 0, 1); idle(2);
        chk(busy == 1'b0, "R10 stale stop", busy, 0);
        step(1, 'h61, 0, 0, 0); step(0, 0, 1, 'h88, 0); step(0, 0, 0, 0, 1);
        idle(P + 2);
        expect_mem('h61, 'h88, "R10 new byte");
        expect_mem('h60, 'h77, "R10 old slot kept");

        // load wins over byte and stop: R11
        step(1, 'h04, 0, 0, 0); step(0, 0, 1, 'hAB, 0);
        step(1, 'h08, 1, 'hCD, 1); idle(2);
        chk(busy == 1'b0, "R11 stop dropped", busy, 0);
        step(0, 0, 0, 0, 1); idle(P + 2);
        expect_mem('h04, 255, "R11 buffer cleared");
        expect_mem('h08, 255, "R11 byte dropped");

        // byte and stop in the same cycle: R5
        step(1, 'h1C, 0, 0, 0); step(0, 0, 1, 'hC3, 1);
        idle(P + 2);
        expect_mem('h1C, 'hC3, "R5 same-cycle stop");
        idle(2);

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule